// File: doc/BRIEF.md
# Line-Cycle Measurement Window Controller

This block sets the timing of the accumulation windows in an energy-metering datapath. A window is a power-of-two count of mains line cycles. The block counts the incoming line-cycle boundary strobes and flags the strobe that closes each window. It also decides whether the downstream RMS, power and energy result registers may take the new values. It does none of that arithmetic itself. It supplies only the counter, the window-complete strobe and the update enable.

Software programs the window length through an exponent write port. A new exponent is held back until the next window starts. In normal operation every completed window updates the results.

Calibration mode freezes the results. While it is on, a single request bit lets exactly one full window of updates through. That window begins at the line-cycle boundary after the request, and the hardware then clears the request bit on its own. Every pin is a plain level or single-clock pulse. No data stream passes through this block, so it has no valid/ready handshake and no back-pressure.

Top module: `line_window_ctrl`

## Requirements
- R1: An active exponent N (0 to 8) makes each window 2^N line-cycle strobes long. For example, N=2 gives 4 strobes and N=8 gives 256 strobes.
- R2: An exponent written with a value above 8 is stored as 8.
- R3: A written exponent does not change the window in progress. It becomes active at the next window start, which is a window end, a calibration arming strobe or a calibration-mode exit. The last value written before that start is the one used.
- R4: `cycle_count` resets to 0 and rises by one on each line strobe. On the strobe seen at count 2^N-1 it returns to 0. Without a strobe it holds its value.
- R5: `window_done` is high for exactly the clock in which `line_tick` is high and `cycle_count` equals 2^N-1. It is driven combinationally in that same cycle.
- R6: With calibration mode off, `update_en` pulses together with every `window_done`. The stored state of `cal_update` makes no difference.
- R7: With calibration mode on and `cal_update` at 0, `update_en` stays low even though windows keep completing.
- R8: When a control write sets calibration mode to 1 and the update bit to 1, the next line strobe starts a window: the counter goes to 0 and `update_en` stays low on that strobe. Exactly 2^N further strobes later, `update_en` pulses once, with `window_done`.
- R9: In the clock after that one-shot `update_en`, `cal_update` reads 0, and no further `update_en` occurs until the update bit is written to 1 again.
- R10: A control write with mode 0 and update 1 leaves `cal_update` reading 1 and starts no one-shot. Updates continue free-running as in R6.
- R11: A control write that changes calibration mode from 1 to 0 sets `cycle_count` to 0 in the next clock. Free-running updates continue from the following strobes.
- R12: A synchronous active-high `rst` clears the active and pending exponents, the counter, the calibration mode and the update bit. After reset every strobe completes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-clock pulse at each line-cycle boundary |
| exp_wr | input | 1 | Write strobe for the window exponent |
| exp_wr_data | input | 16 | Exponent value to write (saturated to 8) |
| ctl_wr | input | 1 | Write strobe for the two control bits |
| ctl_mode | input | 1 | Calibration mode value written on `ctl_wr` |
| ctl_update | input | 1 | Update request value written on `ctl_wr` |
| cycle_count | output | 8 | Line cycles counted so far in the current window |
| window_done | output | 1 | Pulse on the strobe that closes a window |
| update_en | output | 1 | Result-register update enable |
| cal_update | output | 1 | Update request bit, cleared by hardware after its window |

## Verification
The assertions check these every cycle:
- the active exponent never exceeds 8 and changes only at a window start;
- the counter stays inside the window, steps by one per strobe and holds otherwise;
- `update_en` never appears without `window_done`, and never while calibration is frozen;
- the request bit falls only after its window's update or after a software write.

Only the bench scenarios can show:
- that the window lengths are right for each exponent;
- that a deferred exponent lands on the correct strobe;
- that the calibration window starts one strobe late and yields exactly one update;
- that leaving calibration mode restarts the count.

// File: rtl/line_window_pkg.sv
package line_window_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE  = 2'd0,
    CAL_ARMED = 2'd1,
    CAL_RUN   = 2'd2
  } cal_phase_e;
endpackage

// File: rtl/lw_exp_reg.sv
module lw_exp_reg #(
  parameter int MAX_EXP = 8,
  parameter int WR_W    = 16,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             win_start,
  output logic [EXP_W-1:0] active_exp
);
  logic [EXP_W-1:0] pend_q, wr_sat, pend_next, active_q;

  // Clamp oversize writes to the largest legal exponent
  always_comb begin
    if (wr_data > WR_W'(MAX_EXP)) wr_sat = EXP_W'(MAX_EXP);
    else                          wr_sat = wr_data[EXP_W-1:0];
    pend_next = wr_en ? wr_sat : pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      active_q <= '0;
    end else begin
      pend_q <= pend_next;
      if (win_start) active_q <= pend_next;
    end
  end

  assign active_exp = active_q;

  assert_exp_sat_R2: assert property (@(posedge clk) disable iff (rst)
    active_q <= EXP_W'(MAX_EXP));

  assert_exp_deferred_R3: assert property (@(posedge clk) disable iff (rst)
    !win_start |=> $stable(active_q));
endmodule

// File: rtl/lw_cycle_counter.sv
module lw_cycle_counter #(
  parameter int CNT_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_i,
  output logic [CNT_W-1:0] cnt,
  output logic             last_hit
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last_idx, cnt_q;

  always_comb begin
    span     = (CNT_W+1)'(1) << exp_i;
    last_idx = CNT_W'(span - (CNT_W+1)'(1));
    last_hit = tick && (cnt_q == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick)     cnt_q <= last_hit ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx);

  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && !last_hit) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt_q));

  assert_cnt_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    last_hit |=> cnt_q == '0);
endmodule

// File: rtl/lw_cal_gate.sv
module lw_cal_gate
  import line_window_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic mode_in,
  input  logic upd_in,
  input  logic tick,
  input  logic window_done,
  output logic update_en,
  output logic cal_update,
  output logic restart
);
  logic       mode_q, upd_q;
  cal_phase_e phase_q;
  logic       run_end, mode_fall, arm_tick;

  always_comb begin
    run_end   = (phase_q == CAL_RUN) && window_done;
    mode_fall = ctl_wr && mode_q && !mode_in;
    arm_tick  = (phase_q == CAL_ARMED) && tick && !ctl_wr;
    update_en = mode_q ? run_end : window_done;
    restart   = mode_fall || arm_tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      upd_q   <= 1'b0;
      phase_q <= CAL_IDLE;
    end else if (ctl_wr) begin
      mode_q <= mode_in;
      upd_q  <= upd_in;
      if (mode_in && upd_in)
        phase_q <= (phase_q == CAL_IDLE) ? CAL_ARMED : phase_q;
      else
        phase_q <= CAL_IDLE;
    end else begin
      case (phase_q)
        CAL_ARMED: if (tick) phase_q <= CAL_RUN;
        CAL_RUN: if (window_done) begin
          phase_q <= CAL_IDLE;
          upd_q   <= 1'b0;
        end
        default: phase_q <= CAL_IDLE;
      endcase
    end
  end

  assign cal_update = upd_q;

  assert_upd_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
    update_en |-> window_done);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !upd_q) |-> !update_en);

  assert_oneshot_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q && update_en && !ctl_wr) |=> !upd_q);

  assert_clear_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_q) |-> ($past(ctl_wr) || $past(update_en)));

  assert_mode_exit_R11: assert property (@(posedge clk) disable iff (rst)
    mode_fall |=> (phase_q == CAL_IDLE));
endmodule

// File: rtl/line_window_ctrl.sv
module line_window_ctrl #(
  parameter int MAX_EXP = 8,
  parameter int WR_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_tick,
  input  logic               exp_wr,
  input  logic [WR_W-1:0]    exp_wr_data,
  input  logic               ctl_wr,
  input  logic               ctl_mode,
  input  logic               ctl_update,
  output logic [MAX_EXP-1:0] cycle_count,
  output logic               window_done,
  output logic               update_en,
  output logic               cal_update
);
  localparam int EXP_W = $clog2(MAX_EXP + 1);
  localparam int CNT_W = MAX_EXP;

  logic [EXP_W-1:0] active_exp;
  logic             last_hit, restart, win_start;

  assign win_start   = last_hit || restart;
  assign window_done = last_hit;

  lw_exp_reg #(.MAX_EXP(MAX_EXP), .WR_W(WR_W), .EXP_W(EXP_W)) u_exp (
    .clk(clk), .rst(rst), .wr_en(exp_wr), .wr_data(exp_wr_data),
    .win_start(win_start), .active_exp(active_exp)
  );

  lw_cycle_counter #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(line_tick), .restart(restart),
    .exp_i(active_exp), .cnt(cycle_count), .last_hit(last_hit)
  );

  lw_cal_gate u_cal (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .mode_in(ctl_mode),
    .upd_in(ctl_update), .tick(line_tick), .window_done(last_hit),
    .update_en(update_en), .cal_update(cal_update), .restart(restart)
  );

  assert_done_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    window_done |-> line_tick);
endmodule

// File: tb/line_window_ctrl_test.sv
module line_window_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_tick = 1'b0;
  logic        exp_wr = 1'b0;
  logic [15:0] exp_wr_data = '0;
  logic        ctl_wr = 1'b0, ctl_mode = 1'b0, ctl_update = 1'b0;
  logic [7:0]  cycle_count;
  logic        window_done, update_en, cal_update;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_window_ctrl uut (
    .clk(clk), .rst(rst), .line_tick(line_tick), .exp_wr(exp_wr),
    .exp_wr_data(exp_wr_data), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .ctl_update(ctl_update), .cycle_count(cycle_count),
    .window_done(window_done), .update_en(update_en), .cal_update(cal_update)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] val;
    logic [15:0] ticks;
    logic [7:0]  dones;
    logic [7:0]  cnt;
  } vec_t;

  // Free-running mode: updates expected equal to dones
  localparam vec_t VECS [12] = '{
    '{1'b0, 16'd0,  16'd3,   8'd3, 8'd0},   // R1 N=0
    '{1'b1, 16'd2,  16'd5,   8'd2, 8'd0},   // R3 load at end, R1 N=2
    '{1'b1, 16'd1,  16'd2,   8'd0, 8'd2},   // R3 deferred
    '{1'b0, 16'd0,  16'd3,   8'd1, 8'd1},   // R4 wrap
    '{1'b0, 16'd0,  16'd3,   8'd2, 8'd0},   // R1 N=1
    '{1'b1, 16'd15, 16'd1,   8'd0, 8'd1},   // R2 write 15
    '{1'b0, 16'd0,  16'd1,   8'd1, 8'd0},
    '{1'b0, 16'd0,  16'd255, 8'd0, 8'd255}, // R2 saturated to 8
    '{1'b0, 16'd0,  16'd1,   8'd1, 8'd0},   // R1 256 strobes
    '{1'b1, 16'd0,  16'd256, 8'd1, 8'd0},
    '{1'b1, 16'd3,  16'd1,   8'd1, 8'd0},
    '{1'b0, 16'd0,  16'd8,   8'd1, 8'd0}    // R1 N=3
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n, output int nd, output int nu);
    nd = 0; nu = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_tick = 1'b1;
      #1;
      nd += int'(window_done);
      nu += int'(update_en);
      @(negedge clk); line_tick = 1'b0;
    end
  endtask

  task automatic tick1(output bit d, output bit u);
    @(negedge clk); line_tick = 1'b1;
    #1; d = window_done; u = update_en;
    @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic write_exp(input int v);
    @(negedge clk); exp_wr = 1'b1; exp_wr_data = 16'(v);
    @(negedge clk); exp_wr = 1'b0;
  endtask

  task automatic write_ctl(input bit m, input bit u);
    @(negedge clk); ctl_wr = 1'b1; ctl_mode = m; ctl_update = u;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nd, nu;
    bit d, u;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cycle_count == 0, "R12 reset count", cycle_count, 0);
    check(cal_update == 0, "R12 reset update bit", cal_update, 0);
    check(window_done == 0, "R5 no done without strobe", window_done, 0);

    for (int k = 0; k < 12; k++) begin
      if (VECS[k].wr) write_exp(int'(VECS[k].val));
      ticks(int'(VECS[k].ticks), nd, nu);
      check(nd == int'(VECS[k].dones), $sformatf("R1/R5 vec%0d dones", k), nd, int'(VECS[k].dones));
      check(nu == nd, $sformatf("R6 vec%0d updates", k), nu, nd);
      check(cycle_count == VECS[k].cnt, $sformatf("R4 vec%0d count", k), cycle_count, int'(VECS[k].cnt));
    end

    // R3: switch to N=1 at end of the 8-strobe window
    write_exp(1);
    ticks(8, nd, nu);
    check(nd == 1, "R3 exponent applied after window", nd, 1);

    // R7: calibration mode, no request -> frozen
    write_ctl(1'b1, 1'b0);
    ticks(4, nd, nu);
    check(nd == 2, "R7 windows still complete", nd, 2);
    check(nu == 0, "R7 frozen updates", nu, 0);

    // R8: arm mid-window
    ticks(1, nd, nu);
    write_ctl(1'b1, 1'b1);
    check(cal_update == 1, "R8 request bit set", cal_update, 1);
    tick1(d, u);
    check(d == 1, "R8 arming strobe closes old window", d, 1);
    check(u == 0, "R8 no update on arming strobe", u, 0);
    check(cycle_count == 0, "R8 counter restarted", cycle_count, 0);
    tick1(d, u);
    check(u == 0, "R8 no update mid window", u, 0);
    tick1(d, u);
    check(u == 1 && d == 1, "R8 one-shot update", u, 1);
    check(cal_update == 0, "R9 bit self-cleared", cal_update, 0);
    ticks(4, nd, nu);
    check(nu == 0, "R9 no further updates", nu, 0);
    check(nd == 2, "R9 windows continue", nd, 2);

    // R8: arm at count 0
    write_ctl(1'b1, 1'b1);
    ticks(2, nd, nu);
    check(nu == 0 && nd == 0, "R8 waits full window", nu + nd, 0);
    ticks(1, nd, nu);
    check(nu == 1, "R8 second one-shot", nu, 1);
    check(cal_update == 0, "R9 cleared again", cal_update, 0);

    // R11 / R10: leave calibration mid-window with update bit written 1
    ticks(1, nd, nu);
    check(cycle_count == 1, "R11 mid-window count", cycle_count, 1);
    write_ctl(1'b0, 1'b1);
    check(cycle_count == 0, "R11 restart on mode exit", cycle_count, 0);
    check(cal_update == 1, "R10 bit holds as written", cal_update, 1);
    ticks(4, nd, nu);
    check(nd == 2 && nu == 2, "R10 free-running updates", nu, 2);
    check(cal_update == 1, "R10 bit still held", cal_update, 1);

    // R12: reset mid-operation with a pending exponent
    ticks(1, nd, nu);
    write_exp(5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check(cycle_count == 0, "R12 count cleared", cycle_count, 0);
    check(cal_update == 0, "R12 bit cleared", cal_update, 0);
    ticks(3, nd, nu);
    check(nd == 3, "R12 exponent back to 0", nd, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule